// File: doc/BRIEF.md
# CAN Bit Timing Sampler

This block cuts every bit on a CAN bus into time quanta and marks two moments in each bit for the rest of the controller. The first is the transmit point, where the transmitter puts the next bit on the wire. The second is the sample point, where the receiver latches the bus value. A prescaler outside the block supplies a one-cycle quantum tick. The bit counter moves only on that tick.

An 8-bit configuration byte sets the timing. Bit 7 selects the sampling mode. Bits 6:4 hold the phase-2 length field and bits 3:0 hold the phase-1 length field. A bit is built as follows:

- a sync quantum comes first;
- phase 1 follows and lasts (field + 1) quanta;
- phase 2 follows and lasts (field + 1) quanta.

The sample point sits at the end of phase 1. In triple mode the sampled value is the majority of three quantum-spaced readings, and the reading at the sample point is the last of the three.

The configuration is latched only when a new bit begins. The controller raises a bus-idle flag between frames. While that flag is high, a falling edge on the receive line (recessive 1 to dominant 0) restarts the bit at the sync quantum. All other edges are ignored.

Top module: `can_bit_timer`

## Requirements
- R1: Configuration byte layout: bit 7 = triple-sample flag, bits 6:4 = phase-2 field, bits 3:0 = phase-1 field. The latched copy resets to 0, so the first bit after reset lasts 3 quanta and samples at its 2nd quantum tick.
- R2: Counted from the tick that produced a transmit strobe, the next transmit strobe follows on tick number phase1 + phase2 + 3.
- R3: The sample strobe follows tick number phase1 + 2 of the bit, which is the tick that ends phase 1.
- R4: Each strobe is high for exactly one clock. It appears in the clock after the quantum tick that caused it.
- R5: With bit 7 = 0, rx_bit takes the value of rx_in on the sample tick.
- R6: With bit 7 = 1, rx_bit takes the majority of rx_in at ticks phase1, phase1 + 1 and phase1 + 2 of the bit. This holds for all eight patterns.
- R7: With no quantum tick, the counter holds and no strobe is produced.
- R8: While bus_idle = 1, a 1-to-0 edge on rx_in restarts the bit, so the sample and transmit strobes then follow on ticks phase1 + 2 and phase1 + phase2 + 3. A 0-to-1 edge has no effect, and neither does any edge while bus_idle = 0.
- R9: A restart edge that falls on the same clock as the sample tick wins. No sample strobe is produced, and the new bit timing starts from that clock.
- R10: A configuration change written in the middle of a bit leaves that bit's timing unchanged. The change takes effect from the next bit.
- R11: In reset and just after it, tx_pt = 0, smp_pt = 0 and rx_bit = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tq_tick | input | 1 | One-cycle time-quantum enable |
| rx_in | input | 1 | Serial receive line, 1 = recessive |
| bus_idle | input | 1 | High between frames; allows edge restart |
| cfg_byte | input | 8 | Timing configuration byte |
| tx_pt | output | 1 | Transmit-point strobe |
| smp_pt | output | 1 | Sample-point strobe |
| rx_bit | output | 1 | Sampled bit value |

## Verification
The edge restart and the sample-point tick can land in the same clock. When that happens, the two try to steer the counter in different directions. To provoke it, the bench counts ticks up to the one that would end phase 1. It then drives the falling edge on that same clock, with bus_idle high. The pass condition has two parts: no sample strobe appears for that tick, and the next sample strobe arrives phase1 + 2 ticks later, measured from the restart.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int TS1_W  = 4;
  localparam int TS2_W  = 3;
  localparam int NVOTE  = 3;
  localparam int MAX_TQ = 1 + (1 << TS1_W) + (1 << TS2_W);
  localparam int Q_W    = $clog2(MAX_TQ);

  typedef struct packed {
    logic             triple;
    logic [TS2_W-1:0] ph2;
    logic [TS1_W-1:0] ph1;
  } bt_cfg_t;

  function automatic logic vote3(input logic [NVOTE-1:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/bt_cfg_hold.sv
module bt_cfg_hold
  import can_bt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  bt_cfg_t cfg_in,
  output bt_cfg_t cfg_q
);
  bt_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R10: the held timing only moves at a bit boundary
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));
endmodule

// File: rtl/bt_quanta_ctr.sv
module bt_quanta_ctr
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [TS1_W-1:0] ph1,
  input  logic [TS2_W-1:0] ph2,
  output logic             wrap,
  output logic             smp_tick,
  output logic             tx_pt,
  output logic             smp_pt
);
  logic [Q_W-1:0] q, q_d;
  logic [Q_W-1:0] smp_q, last_q;

  always_comb begin
    smp_q    = Q_W'(ph1) + Q_W'(1);
    last_q   = smp_q + Q_W'(ph2) + Q_W'(1);
    wrap     = tick && !restart && (q >= last_q);
    smp_tick = tick && !restart && (q == smp_q);
    q_d      = q;
    if (restart)   q_d = '0;
    else if (wrap) q_d = '0;
    else if (tick) q_d = q + Q_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      tx_pt  <= 1'b0;
      smp_pt <= 1'b0;
    end else begin
      q      <= q_d;
      tx_pt  <= wrap;
      smp_pt <= smp_tick;
    end
  end

  a_r4_tx_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pt |=> !tx_pt);
  a_r4_smp_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    smp_pt |=> !smp_pt);
  a_r2_tx_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pt |-> (q == '0));
  a_r7_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(q));
  a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (q == '0) && !smp_pt && !tx_pt);
endmodule

// File: rtl/bt_edge_realign.sv
module bt_edge_realign (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic bus_idle,
  output logic restart
);
  logic rx_prev;

  always_comb restart = bus_idle && rx_prev && !rx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_prev <= 1'b1;
    else        rx_prev <= rx_in;
  end

  // R8: no restart while a frame is on the bus
  a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |-> !restart);
endmodule

// File: rtl/bt_sampler.sv
module bt_sampler
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic smp_tick,
  input  logic triple,
  input  logic rx_in,
  output logic rx_bit
);
  logic [NVOTE-2:0] hist, hist_d;
  logic             bit_d;

  always_comb begin
    hist_d = hist;
    if (tick) hist_d = {hist[NVOTE-3:0], rx_in};
    bit_d = rx_bit;
    if (smp_tick) bit_d = triple ? vote3({hist, rx_in}) : rx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '1;
      rx_bit <= 1'b1;
    end else begin
      hist   <= hist_d;
      rx_bit <= bit_d;
    end
  end

  a_r5_single_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_tick && !triple) |=> (rx_bit == $past(rx_in)));
  a_r6_vote_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_tick && triple && rx_in && hist[0]) |=> rx_bit);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tq_tick,
  input  logic                        rx_in,
  input  logic                        bus_idle,
  input  logic [$bits(bt_cfg_t)-1:0]  cfg_byte,
  output logic                        tx_pt,
  output logic                        smp_pt,
  output logic                        rx_bit
);
  bt_cfg_t cfg_q;
  logic    restart, wrap, smp_tick, cfg_load;

  always_comb cfg_load = wrap || restart;

  bt_edge_realign u_edge (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .bus_idle(bus_idle),
    .restart(restart)
  );

  bt_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .cfg_in(bt_cfg_t'(cfg_byte)), .cfg_q(cfg_q)
  );

  bt_quanta_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tq_tick), .restart(restart),
    .ph1(cfg_q.ph1), .ph2(cfg_q.ph2), .wrap(wrap), .smp_tick(smp_tick),
    .tx_pt(tx_pt), .smp_pt(smp_pt)
  );

  bt_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .tick(tq_tick), .smp_tick(smp_tick),
    .triple(cfg_q.triple), .rx_in(rx_in), .rx_bit(rx_bit)
  );

  // R4: a strobe is always the echo of a quantum tick
  a_r4_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pt || smp_pt) |-> $past(tq_tick));
  a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pt && smp_pt));
endmodule

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
  logic clk, rst_n, tq_tick, rx_in, bus_idle;
  logic [7:0] cfg_byte;
  logic tx_pt, smp_pt, rx_bit;
  int n_chk, n_fail;
  bit done;

  can_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_in(rx_in),
    .bus_idle(bus_idle), .cfg_byte(cfg_byte), .tx_pt(tx_pt),
    .smp_pt(smp_pt), .rx_bit(rx_bit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed { logic [7:0] cfg; int smp; int len; } vec_t;
  localparam vec_t VECS [4] = '{
    '{8'h00, 2, 3}, '{8'h7F, 17, 25}, '{8'h35, 7, 11}, '{8'hA2, 4, 7}
  };
  // pattern bits [3:1] = readings at ticks ph1, ph1+1, ph1+2; bit [0] = majority
  localparam logic [3:0] MAJ [8] = '{
    4'b0000, 4'b0010, 4'b0100, 4'b0111, 4'b1000, 4'b1011, 4'b1101, 4'b1111
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick1(output logic t, output logic s);
    @(negedge clk); tq_tick = 1'b1;
    @(negedge clk); tq_tick = 1'b0;
    t = tx_pt; s = smp_pt;
    @(negedge clk);
    if (t || s) chk(!tx_pt && !smp_pt, "R4 strobe width", int'(tx_pt | smp_pt), 0);
  endtask

  task automatic sync_bit();
    logic t, s;
    for (int n = 0; n < 40; n++) begin
      tick1(t, s);
      if (t) break;
    end
  endtask

  task automatic measure(output int smp_at, output int len);
    logic t, s;
    smp_at = -1; len = -1;
    for (int n = 1; n <= 40; n++) begin
      tick1(t, s);
      if (s && smp_at < 0) smp_at = n;
      if (t) begin len = n; break; end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int sa, ln;
    logic t, s;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; tq_tick = 1'b0; rx_in = 1'b1; bus_idle = 1'b0; cfg_byte = 8'h7F;
    repeat (3) @(negedge clk);
    chk(!tx_pt && !smp_pt && rx_bit, "R11 reset outputs", {tx_pt, smp_pt, rx_bit}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_pt && !smp_pt && rx_bit, "R11 after release", {tx_pt, smp_pt, rx_bit}, 1);

    // R1: held copy resets to zero -> first bit 3 quanta, sample at tick 2
    measure(sa, ln);
    chk(sa == 2, "R1 first-bit sample", sa, 2);
    chk(ln == 3, "R1 first-bit length", ln, 3);

    // R7: no ticks, no strobes
    begin
      int seen = 0;
      repeat (60) begin @(negedge clk); if (tx_pt || smp_pt) seen++; end
      chk(seen == 0, "R7 no tick no strobe", seen, 0);
    end

    // R2 R3: vector table
    foreach (VECS[i]) begin
      cfg_byte = VECS[i].cfg;
      sync_bit(); sync_bit();
      measure(sa, ln);
      chk(sa == VECS[i].smp, "R3 sample position", sa, VECS[i].smp);
      chk(ln == VECS[i].len, "R2 bit length", ln, VECS[i].len);
    end

    // R6: all eight patterns, triple mode, ph1 = 2 -> readings at ticks 2,3,4
    cfg_byte = 8'hA2;
    sync_bit(); sync_bit();
    foreach (MAJ[i]) begin
      logic got;
      got = 1'bx;
      for (int n = 1; n <= 7; n++) begin
        rx_in = (n == 2) ? MAJ[i][3] : (n == 3) ? MAJ[i][2] : (n == 4) ? MAJ[i][1] : 1'b1;
        tick1(t, s);
        if (s) got = rx_bit;
      end
      rx_in = 1'b1;
      chk(got === MAJ[i][0], "R6 majority", int'(got), int'(MAJ[i][0]));
    end

    // R5: single mode, pattern 1,1,0 -> takes the last reading 0
    cfg_byte = 8'h22;
    sync_bit(); sync_bit();
    begin
      logic got;
      got = 1'bx;
      for (int n = 1; n <= 7; n++) begin
        rx_in = (n == 4) ? 1'b0 : 1'b1;
        tick1(t, s);
        if (s) got = rx_bit;
      end
      rx_in = 1'b1;
      chk(got === 1'b0, "R5 single sample", int'(got), 0);
    end

    // R10: mid-bit change keeps the running bit
    cfg_byte = 8'h35;
    sync_bit(); sync_bit();
    cfg_byte = 8'h00;
    measure(sa, ln);
    chk(sa == 7 && ln == 11, "R10 old timing kept", sa * 100 + ln, 711);
    measure(sa, ln);
    chk(sa == 2 && ln == 3, "R10 new timing next bit", sa * 100 + ln, 203);

    // R8: falling edge while idle restarts the bit
    cfg_byte = 8'h35;
    sync_bit(); sync_bit();
    bus_idle = 1'b1;
    repeat (4) tick1(t, s);
    @(negedge clk); rx_in = 1'b0;
    @(negedge clk);
    measure(sa, ln);
    chk(sa == 7 && ln == 11, "R8 restart on fall", sa * 100 + ln, 711);
    // R8: rising edge while idle is ignored
    sync_bit();
    repeat (4) tick1(t, s);
    @(negedge clk); rx_in = 1'b1;
    @(negedge clk);
    measure(sa, ln);
    chk(sa == 3 && ln == 7, "R8 rise ignored", sa * 100 + ln, 307);
    // R8: falling edge while busy is ignored
    bus_idle = 1'b0;
    sync_bit();
    repeat (4) tick1(t, s);
    @(negedge clk); rx_in = 1'b0;
    @(negedge clk); rx_in = 1'b1;
    @(negedge clk);
    measure(sa, ln);
    chk(sa == 3 && ln == 7, "R8 busy edge ignored", sa * 100 + ln, 307);

    // R9: restart edge on the sample tick wins
    sync_bit();
    bus_idle = 1'b1;
    repeat (6) tick1(t, s);
    @(negedge clk); tq_tick = 1'b1; rx_in = 1'b0;
    @(negedge clk); tq_tick = 1'b0;
    chk(!smp_pt && !tx_pt, "R9 no strobe on clash", int'(smp_pt | tx_pt), 0);
    rx_in = 1'b0;
    measure(sa, ln);
    chk(sa == 7 && ln == 11, "R9 timing from restart", sa * 100 + ln, 711);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule